// File: doc/BRIEF.md
# Interrupt Flag and Wake-up Controller

This block collects interrupt requests for a small 8-bit microcontroller. Eight sources feed one sticky status register: a timer overflow strobe, an ADC-complete strobe, three PWM period-match strobes, the falling edge of an external interrupt pin, a change on any bit of a monitored input port, and a change of a comparator output. The asynchronous inputs (pin, port, comparator) pass through a synchronizer chain before edge and change detection.

Software reaches three registers over a simple single-cycle bus. Status is read through the mask, so only enabled requests are visible. A status write can only clear flags. A separate wake-up register enables three sources (ADC complete, comparator change, port change) to wake the core while it sleeps, independent of the mask and the global enable. A global enable, set and cleared by two strobes from the core, gates the interrupt request output.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset all status flags, the mask, the wake-up enables and the global enable are 0, so `irq_o`, `wake_o` and every register read return 0.
- R2: Status bit positions are fixed: bit 0 timer overflow, bit 1 port change, bit 2 external pin, bit 3 ADC done, bits 4..6 PWM match 0..2, bit 7 comparator; a strobe held high across one rising clock edge sets its flag at that edge.
- R3: The external-pin flag (bit 2) is set by a high-to-low transition of `ext_pin_i`, at the third rising edge after the change with two synchronizer stages; a rising transition sets nothing.
- R4: Any change of any bit of `port_i` sets bit 1, and any change of `cmp_i` sets bit 7, with the same latency as R3.
- R5: A write to address 0 clears each flag whose written data bit is 0 and leaves flags whose data bit is 1 unchanged; it never sets a flag.
- R6: A read of address 0 returns the status flags ANDed with the mask; address 3 reads 0.
- R7: Address 1 holds the mask; a write stores all 8 bits and a read returns them.
- R8: When a source sets a flag in the same cycle that a status write clears it, the flag ends up set.
- R9: `gie_set_i` turns the global enable on and `gie_clr_i` turns it off; if both are high in one cycle, the enable ends up off.
- R10: `irq_o` is high exactly when the global enable is on and at least one flag is set with its mask bit set.
- R11: Address 2 is the wake-up control register: bit 1 enables port-change wake-up, bit 2 comparator-change wake-up, bit 3 ADC-complete wake-up; bits 0 and 7..4 always read 0.
- R12: `wake_o` is a one-cycle pulse, registered at the same edge that sets the flag, when `sleep_i` is high at that edge and an event occurs on a wake-enabled source; mask and global enable do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| sleep_i | input | 1 | Core is in sleep mode |
| tmr_ovf_i | input | 1 | Timer overflow strobe |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| port_i | input | PORT_W | Monitored input port, asynchronous |
| adc_done_i | input | 1 | ADC conversion complete strobe |
| pwm_match_i | input | 3 | PWM period-match strobes |
| cmp_i | input | 1 | Comparator output, asynchronous |
| bus_addr_i | input | ADDR_W | Register select: 0 status, 1 mask, 2 wake-up control |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| gie_set_i | input | 1 | Global interrupt enable strobe |
| gie_clr_i | input | 1 | Global interrupt disable strobe |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake-up pulse to the core |

## Verification
The bench builds the block with an 8-bit port, two synchronizer stages and a 2-bit address, so every flag, every mask bit and all four addresses, including the unused one, are reachable, and the three-edge detection latency of the asynchronous inputs is short enough to probe cycle by cycle. Random traffic overlaps strobes, status clears, mask and wake-up writes, sleep toggles and simultaneous enable/disable strobes, which drives the set-versus-clear and enable-versus-disable collisions many times. Directed passes pin down the falling-edge-only rule of the external pin, the latency of the synchronized inputs and wake-up with mask and global enable both off.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_PWM  = 3;
  localparam int unsigned BIT_TMR  = 0;
  localparam int unsigned BIT_PORT = 1;
  localparam int unsigned BIT_EXT  = 2;
  localparam int unsigned BIT_ADC  = 3;
  localparam int unsigned BIT_PWM0 = 4;
  localparam int unsigned BIT_CMP  = 7;
  localparam int unsigned NUM_WK   = 3;
  localparam int unsigned WK_LSB   = 1;
  localparam int unsigned WK_PORT  = 0;
  localparam int unsigned WK_CMP   = 1;
  localparam int unsigned WK_ADC   = 2;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_WAKE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqw_sync.sv
module irqw_sync #(
  parameter int unsigned W      = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0]             prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign cur_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/irqw_flags.sv
module irqw_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;

  // hardware set is ORed in last so it wins over a same-cycle clear
  always_comb begin
    flags_d = flags_q;
    if (clr_we_i) flags_d = flags_d & keep_i;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irqw_regs.sv
module irqw_regs
  import irqw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              mask_we_i,
  input  logic              wake_we_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  output logic [REG_W-1:0]  mask_o,
  output logic [NUM_WK-1:0] wake_en_o,
  output logic              gie_o
);
  logic [REG_W-1:0]  mask_q,  mask_d;
  logic [NUM_WK-1:0] wken_q,  wken_d;
  logic              gie_q,   gie_d;

  always_comb begin
    mask_d = mask_q;
    wken_d = wken_q;
    gie_d  = gie_q;
    if (mask_we_i) mask_d = wdata_i;
    if (wake_we_i) wken_d = wdata_i[WK_LSB +: NUM_WK];
    if (gie_set_i) gie_d = 1'b1;
    if (gie_clr_i) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      wken_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      wken_q <= wken_d;
      gie_q  <= gie_d;
    end
  end

  assign mask_o    = mask_q;
  assign wake_en_o = wken_q;
  assign gie_o     = gie_q;
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irqw_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_i,
  input  logic                tmr_ovf_i,
  input  logic                ext_pin_i,
  input  logic [PORT_W-1:0]   port_i,
  input  logic                adc_done_i,
  input  logic [NUM_PWM-1:0]  pwm_match_i,
  input  logic                cmp_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  input  logic                gie_set_i,
  input  logic                gie_clr_i,
  output logic                irq_o,
  output logic                wake_o
);
  localparam int unsigned SYNC_W = PORT_W + 2;
  localparam int unsigned IDX_EXT = PORT_W;
  localparam int unsigned IDX_CMP = PORT_W + 1;

  logic [SYNC_W-1:0]  sync_cur, sync_prev;
  logic               ext_fall, port_chg, cmp_chg;
  logic [REG_W-1:0]   set_vec;
  logic [REG_W-1:0]   flags_q, mask_q;
  logic [NUM_WK-1:0]  wake_en;
  logic               gie_q;
  logic               sel_stat, sel_mask, sel_wake;
  logic               wake_d, wake_q;

  irqw_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cmp_i, ext_pin_i, port_i}),
    .cur_o   (sync_cur),
    .prev_o  (sync_prev)
  );

  always_comb begin
    ext_fall = sync_prev[IDX_EXT] & ~sync_cur[IDX_EXT];
    port_chg = |(sync_prev[PORT_W-1:0] ^ sync_cur[PORT_W-1:0]);
    cmp_chg  = sync_prev[IDX_CMP] ^ sync_cur[IDX_CMP];
  end

  always_comb begin
    set_vec                        = '0;
    set_vec[BIT_TMR]               = tmr_ovf_i;
    set_vec[BIT_PORT]              = port_chg;
    set_vec[BIT_EXT]               = ext_fall;
    set_vec[BIT_ADC]               = adc_done_i;
    set_vec[BIT_PWM0 +: NUM_PWM]   = pwm_match_i;
    set_vec[BIT_CMP]               = cmp_chg;
  end

  always_comb begin
    sel_stat = (bus_addr_i == ADDR_W'(SEL_STAT));
    sel_mask = (bus_addr_i == ADDR_W'(SEL_MASK));
    sel_wake = (bus_addr_i == ADDR_W'(SEL_WAKE));
  end

  irqw_flags #(.W(REG_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_we_i (bus_wr_i & sel_stat),
    .keep_i   (bus_wdata_i),
    .flags_o  (flags_q)
  );

  irqw_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata_i   (bus_wdata_i),
    .mask_we_i (bus_wr_i & sel_mask),
    .wake_we_i (bus_wr_i & sel_wake),
    .gie_set_i (gie_set_i),
    .gie_clr_i (gie_clr_i),
    .mask_o    (mask_q),
    .wake_en_o (wake_en),
    .gie_o     (gie_q)
  );

  // wake-up pulse, registered at the edge that also sets the flag
  always_comb begin
    wake_d = sleep_i & ((wake_en[WK_PORT] & port_chg) |
                        (wake_en[WK_CMP]  & cmp_chg)  |
                        (wake_en[WK_ADC]  & adc_done_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel_stat) bus_rdata_o = flags_q & mask_q;
    if (sel_mask) bus_rdata_o = mask_q;
    if (sel_wake) bus_rdata_o[WK_LSB +: NUM_WK] = wake_en;
  end

  assign irq_o  = gie_q & |(flags_q & mask_q);
  assign wake_o = wake_q;
endmodule

// File: rtl/irqw_chk.sv
module irqw_chk #(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_i,
  input logic              tmr_ovf_i,
  input logic              adc_done_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        bus_rdata_o,
  input logic              gie_clr_i,
  input logic              irq_o,
  input logic              wake_o,
  input logic [7:0]        flags,
  input logic [7:0]        mask,
  input logic              gie
);
  assert_tmr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> flags[0]);

  assert_no_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_ovf_i && !flags[0]) |=> !flags[0]);

  assert_mask_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(1)) |=> (mask == $past(bus_wdata_i)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done_i && bus_wr_i && bus_addr_i == ADDR_W'(0)) |=> flags[3]);

  assert_gie_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |=> !gie);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_o);

  assert_wake_rsv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADDR_W'(2)) |-> (bus_rdata_o[0] == 1'b0 && bus_rdata_o[7:4] == 4'd0));

  assert_wake_sleep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |=> !wake_o);
endmodule

bind irq_wake_ctrl irqw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_i     (sleep_i),
  .tmr_ovf_i   (tmr_ovf_i),
  .adc_done_i  (adc_done_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .gie_clr_i   (gie_clr_i),
  .irq_o       (irq_o),
  .wake_o      (wake_o),
  .flags       (flags_q),
  .mask        (mask_q),
  .gie         (gie_q)
);

// File: tb/sim_irq_wake_ctrl.sv
module sim_irq_wake_ctrl;
  localparam int PORT_W = 8;
  localparam int SYNC   = 2;
  localparam int ADDR_W = 2;

  logic              clk, rst_n, sleep_i, tmr_ovf_i, ext_pin_i, adc_done_i, cmp_i;
  logic [PORT_W-1:0] port_i;
  logic [2:0]        pwm_match_i;
  logic [ADDR_W-1:0] bus_addr_i;
  logic              bus_wr_i, gie_set_i, gie_clr_i;
  logic [7:0]        bus_wdata_i, bus_rdata_o;
  logic              irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_wake_ctrl #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .tmr_ovf_i(tmr_ovf_i),
    .ext_pin_i(ext_pin_i), .port_i(port_i), .adc_done_i(adc_done_i),
    .pwm_match_i(pwm_match_i), .cmp_i(cmp_i), .bus_addr_i(bus_addr_i),
    .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .irq_o(irq_o), .wake_o(wake_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model built from the requirements
  logic [7:0]        m_flags, m_mask, m_set;
  logic [2:0]        m_wken;
  logic              m_gie, m_wake;
  logic              h_ext  [SYNC+1];
  logic              h_cmp  [SYNC+1];
  logic [PORT_W-1:0] h_port [SYNC+1];
  logic              e_fall, e_port, e_cmp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = '0; m_mask = '0; m_wken = '0; m_gie = 1'b0; m_wake = 1'b0;
      for (int i = 0; i <= SYNC; i++) begin
        h_ext[i] = 1'b0; h_cmp[i] = 1'b0; h_port[i] = '0;
      end
    end else begin
      e_fall = h_ext[SYNC] & ~h_ext[SYNC-1];
      e_port = (h_port[SYNC] != h_port[SYNC-1]);
      e_cmp  = (h_cmp[SYNC]  != h_cmp[SYNC-1]);
      m_set  = {e_cmp, pwm_match_i, adc_done_i, e_fall, e_port, tmr_ovf_i};
      m_wake = sleep_i & ((m_wken[0] & e_port) | (m_wken[1] & e_cmp) | (m_wken[2] & adc_done_i));
      if (bus_wr_i && bus_addr_i == 2'd0) m_flags = m_flags & bus_wdata_i;
      m_flags = m_flags | m_set;
      if (bus_wr_i && bus_addr_i == 2'd1) m_mask = bus_wdata_i;
      if (bus_wr_i && bus_addr_i == 2'd2) m_wken = bus_wdata_i[3:1];
      if (gie_clr_i)      m_gie = 1'b0;
      else if (gie_set_i) m_gie = 1'b1;
      for (int i = SYNC; i > 0; i--) begin
        h_ext[i] = h_ext[i-1]; h_cmp[i] = h_cmp[i-1]; h_port[i] = h_port[i-1];
      end
      h_ext[0] = ext_pin_i; h_cmp[0] = cmp_i; h_port[0] = port_i;
    end
  end

  function automatic logic [7:0] exp_rdata(logic [ADDR_W-1:0] a);
    case (a)
      2'd0:    return m_flags & m_mask;
      2'd1:    return m_mask;
      2'd2:    return {4'd0, m_wken, 1'b0};
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    chk(tag, bus_rdata_o, exp_rdata(bus_addr_i));
    chk("R10", {7'd0, irq_o}, {7'd0, m_gie & |(m_flags & m_mask)});
    chk("R12", {7'd0, wake_o}, {7'd0, m_wake});
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, string tag);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    tick(tag);
    bus_wr_i = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; sleep_i = 0; tmr_ovf_i = 0; ext_pin_i = 1; adc_done_i = 0; cmp_i = 0;
    port_i = '0; pwm_match_i = '0; bus_addr_i = '0; bus_wr_i = 0; bus_wdata_i = '0;
    gie_set_i = 0; gie_clr_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_addr_i = a[1:0];
      tick("R1");
      chk("R1", bus_rdata_o, 8'h00);
    end
    chk("R1", {6'd0, irq_o, wake_o}, 8'h00);
    // R7 mask write/read
    wr(2'd1, 8'hFF, "R7");
    tick("R7");
    chk("R7", bus_rdata_o, 8'hFF);
    bus_addr_i = 2'd0;
    // R2 strobes
    tmr_ovf_i = 1; tick("R2"); tmr_ovf_i = 0;
    chk("R2", bus_rdata_o, 8'h01);
    pwm_match_i = 3'b100; tick("R2"); pwm_match_i = 0;
    chk("R2", bus_rdata_o, 8'h41);
    // R9/R10 global enable
    gie_set_i = 1; tick("R9"); gie_set_i = 0;
    chk("R9", {7'd0, irq_o}, 8'h01);
    gie_set_i = 1; gie_clr_i = 1; tick("R9"); gie_set_i = 0; gie_clr_i = 0;
    chk("R9", {7'd0, irq_o}, 8'h00);
    // R5 clear-only writes
    wr(2'd0, 8'hFE, "R5");
    chk("R5", bus_rdata_o, 8'h40);
    wr(2'd0, 8'hFF, "R5");
    chk("R5", bus_rdata_o, 8'h40);
    // R8 set beats same-cycle clear
    adc_done_i = 1; wr(2'd0, 8'h00, "R8"); adc_done_i = 0;
    chk("R8", bus_rdata_o, 8'h08);
    wr(2'd0, 8'h00, "R5");
    // R3 rising edge sets nothing, falling edge sets bit 2 on the third edge
    ext_pin_i = 0; repeat (5) tick("R3");
    ext_pin_i = 1; repeat (5) tick("R3");
    chk("R3", bus_rdata_o, 8'h04);
    wr(2'd0, 8'h00, "R3");
    tick("R3");
    chk("R3", bus_rdata_o, 8'h00);
    ext_pin_i = 0; tick("R3"); tick("R3");
    chk("R3", bus_rdata_o & 8'h04, 8'h00);
    tick("R3");
    chk("R3", bus_rdata_o & 8'h04, 8'h04);
    // R4 port and comparator changes
    wr(2'd0, 8'h00, "R4");
    port_i[5] = 1'b1; repeat (3) tick("R4");
    chk("R4", bus_rdata_o, 8'h02);
    cmp_i = 1'b1; repeat (3) tick("R4");
    chk("R4", bus_rdata_o, 8'h82);
    // R6 masked read
    wr(2'd1, 8'h02, "R6");
    bus_addr_i = 2'd0; tick("R6");
    chk("R6", bus_rdata_o, 8'h02);
    bus_addr_i = 2'd3; tick("R6");
    chk("R6", bus_rdata_o, 8'h00);
    // R11 wake register reserved bits
    wr(2'd2, 8'hFF, "R11");
    tick("R11");
    chk("R11", bus_rdata_o, 8'h0E);
    // R12 wake with mask and global enable off
    wr(2'd1, 8'h00, "R12");
    gie_clr_i = 1; tick("R12"); gie_clr_i = 0;
    sleep_i = 1; port_i[0] = 1'b1;
    tick("R12"); tick("R12");
    chk("R12", {7'd0, wake_o}, 8'h00);
    tick("R12");
    chk("R12", {7'd0, wake_o}, 8'h01);
    tick("R12");
    chk("R12", {7'd0, wake_o}, 8'h00);
    sleep_i = 0; adc_done_i = 1; tick("R12"); adc_done_i = 0;
    chk("R12", {7'd0, wake_o}, 8'h00);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      tmr_ovf_i   = ($urandom_range(7) == 0);
      adc_done_i  = ($urandom_range(7) == 0);
      pwm_match_i = {($urandom_range(7) == 0), ($urandom_range(7) == 0), ($urandom_range(7) == 0)};
      if ($urandom_range(5) == 0) ext_pin_i = ~ext_pin_i;
      if ($urandom_range(5) == 0) port_i[$urandom_range(PORT_W-1)] ^= 1'b1;
      if ($urandom_range(7) == 0) cmp_i = ~cmp_i;
      if ($urandom_range(15) == 0) sleep_i = ~sleep_i;
      gie_set_i   = ($urandom_range(15) == 0);
      gie_clr_i   = ($urandom_range(15) == 0);
      bus_addr_i  = ADDR_W'($urandom_range(3));
      bus_wr_i    = ($urandom_range(3) == 0);
      bus_wdata_i = 8'($urandom);
      tick("R5");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule